// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a general-purpose 32-bit decrementing timer for a processor subsystem. Software programs a start value, picks a divide ratio for the count rate, and chooses whether the timer stops after one expiry or rearms itself from the stored start value. Each time the count steps from one to zero, a sticky status flag is set. The flag drives the interrupt output only while interrupts are enabled.

Software reaches the timer through a small synchronous register port. The port has a 2-bit word address, a write strobe, 32-bit write data and a combinational 32-bit read path. Writes take effect at the rising clock edge. Read data follows the address within the same cycle. Everything runs on one clock with a synchronous active-low reset.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset, the reload register, live count, control register and status flag all read 0, and `irq` is 0.
- R2: The register map is as follows. Address 0 is the reload register: a write stores the value and also copies it into the live count. Address 1 is the live count: a write overwrites the count only. Address 2 is the control register: bit 0 run enable, bit 1 auto-reload, bit 2 interrupt enable, bits 15:8 prescale value P; its other bits read 0. Address 3 is status, with the event flag at bit 0. A write to address 0 or 1 also restarts the prescale phase at zero. Read data is combinational from the address.
- R3: While enabled, the count decrements once every P+1 clock edges, counted from the edge of the last count write or enable.
- R4: When a decrement takes the count from 1 to 0, the status flag sets at that edge.
- R5: In single-shot mode (auto-reload 0) the count stays at 0 after expiry and raises no further events until it is written.
- R6: In auto-reload mode, the first prescaled step taken at count 0 loads the reload value and raises no event. With reload value L > 0, events therefore recur every (L+1)*(P+1) edges.
- R7: Clearing run enable freezes both the count and the prescale phase. Re-enabling resumes from the held phase.
- R8: The status flag is write-one-to-clear. Writing 0 to bit 0 has no effect. If an event and a clearing write fall on the same edge, the flag stays set.
- R9: `irq` is high exactly when the status flag and interrupt enable are both 1.
- R10: A register write to the count takes priority over a decrement or reload on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, level |

## Verification
The embedded assertions check the following on every cycle:
- the count drops by exactly one on a prescaled step;
- in single-shot mode the count holds at zero;
- in auto-reload mode the count takes the reload value from zero;
- nothing moves while stopped, and the prescale phase is held;
- a write wins over a step;
- the status flag sets on an event, clears on a one-write and otherwise holds;
- the interrupt stays masked without its enable.

Some properties only show up over whole runs, so the bench scenarios must cover them:
- the exact cycle at which counts and expiries land for many prescale and start values;
- the full period across reloads;
- resumption from a held prescale phase;
- the status flag staying set when a clear coincides with an expiry.

// File: rtl/tmr_pkg.sv
// Package: shared constants and the control-field type for the prescaled timer.
// Assumes a 2-bit word address; field positions here define the software view.
package tmr_pkg;
    localparam int CNT_W  = 32;
    localparam int PS_W   = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

    localparam int B_RUN   = 0;
    localparam int B_AUTO  = 1;
    localparam int B_IRQEN = 2;
    localparam int B_PS    = 8;

    typedef struct packed {
        logic [PS_W-1:0] prescale;
        logic            irq_en;
        logic            auto_rl;
        logic            run;
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: emits a one-cycle step when the phase counter reaches the divide
// value, giving one step every (div+1) enabled edges. Assumes div may change at
// any time; a phase already past a lowered div steps at once.
module tmr_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] div,
    output logic            tick
);
    logic [PS_W-1:0] phase;

    // Step request: enabled and phase has reached the divide value.
    always_comb tick = run && (phase >= div);

    // Phase counter: restarts on count writes, holds while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (restart) phase <= '0;
        else if (run)     phase <= tick ? '0 : phase + 1'b1;
    end

    assert_phase_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase));
    assert_phase_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));
endmodule

// File: rtl/tmr_decrementer.sv
// Decrementer: holds the live count, steps it down on each prescaled tick,
// reloads from the reload value at zero in auto mode, and flags the 1->0 step.
// Assumes a bus write to the count has priority over any tick in that cycle.
module tmr_decrementer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             auto_rl,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_nx;

    // Next-count selection and expiry detection.
    always_comb begin
        count_nx = count;
        zero_evt = 1'b0;
        if (wr_cnt) begin
            count_nx = wr_val;
        end else if (tick) begin
            if (count == '0) begin
                count_nx = auto_rl ? reload_val : '0;
            end else begin
                count_nx = count - ONE;
                zero_evt = (count == ONE);
            end
        end
    end

    // Live count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nx;
    end

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && count > ONE) |=> (count == $past(count) - ONE));
    assert_shot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && count == '0 && !auto_rl) |=> (count == '0));
    assert_auto_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && count == '0 && auto_rl) |=> (count == $past(reload_val)));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(count));
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count == $past(wr_val)));
endmodule

// File: rtl/tmr_regs.sv
// Register file: decodes the word-addressed bus into the reload and control
// registers, the sticky write-one-to-clear status flag, the count-write strobe
// and the combinational read mux. Assumes one write per cycle, no wait states.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              zero_evt,
    input  logic [CNT_W-1:0]  count,
    output tmr_cfg_t          cfg,
    output logic [CNT_W-1:0]  reload_val,
    output logic              wr_cnt,
    output logic              status,
    output logic [CNT_W-1:0]  bus_rdata
);
    logic wr_reload, wr_ctrl, wr_clear;

    // Write decode.
    always_comb begin
        wr_reload = bus_we && (bus_addr == A_RELOAD);
        wr_cnt    = bus_we && (bus_addr == A_RELOAD || bus_addr == A_COUNT);
        wr_ctrl   = bus_we && (bus_addr == A_CTRL);
        wr_clear  = bus_we && (bus_addr == A_STAT) && bus_wdata[0];
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_val <= '0;
        else if (wr_reload) reload_val <= bus_wdata;
    end

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_ctrl) begin
            cfg.run      <= bus_wdata[B_RUN];
            cfg.auto_rl  <= bus_wdata[B_AUTO];
            cfg.irq_en   <= bus_wdata[B_IRQEN];
            cfg.prescale <= bus_wdata[B_PS +: PS_W];
        end
    end

    // Sticky status flag; a new event beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        status <= 1'b0;
        else if (zero_evt) status <= 1'b1;
        else if (wr_clear) status <= 1'b0;
    end

    // Read mux, combinational from the address.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RELOAD: bus_rdata = reload_val;
            A_COUNT:  bus_rdata = count;
            A_CTRL: begin
                bus_rdata[B_RUN]         = cfg.run;
                bus_rdata[B_AUTO]        = cfg.auto_rl;
                bus_rdata[B_IRQEN]       = cfg.irq_en;
                bus_rdata[B_PS +: PS_W]  = cfg.prescale;
            end
            default:  bus_rdata[0] = status;
        endcase
    end

    assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> status);
    assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && !zero_evt) |=> !status);
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !wr_clear) |=> status);
endmodule

// File: rtl/prescaled_down_timer.sv
// Top: 32-bit prescaled down-counting timer with a four-word register port and
// a level interrupt. Assumes a single clock and synchronous active-low reset.
module prescaled_down_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int PS_W   = tmr_pkg::PS_W,
    parameter int ADDR_W = tmr_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    tmr_cfg_t         cfg;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic             wr_cnt;
    logic             tick;
    logic             zero_evt;
    logic             status;

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .zero_evt(zero_evt), .count(count),
        .cfg(cfg), .reload_val(reload_val), .wr_cnt(wr_cnt),
        .status(status), .bus_rdata(bus_rdata)
    );

    tmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .run(cfg.run), .restart(wr_cnt),
        .div(cfg.prescale), .tick(tick)
    );

    tmr_decrementer #(.CNT_W(CNT_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .tick(tick), .auto_rl(cfg.auto_rl),
        .wr_cnt(wr_cnt), .wr_val(bus_wdata), .reload_val(reload_val),
        .count(count), .zero_evt(zero_evt)
    );

    // Interrupt request: status flag gated by the enable.
    always_comb irq = status && cfg.irq_en;

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.irq_en |-> !irq);
    assert_stopped_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.run && !wr_cnt) |=> $stable(count));
endmodule

// File: tb/sim_prescaled_down_timer.sv
module sim_prescaled_down_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    prescaled_down_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_now(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [31:0] exp_count(int n, int p, bit au, int k);
        int t = k / (p + 1);
        if (au) return 32'(n - (t % (n + 1)));
        return (t >= n) ? 32'd0 : 32'(n - t);
    endfunction

    function automatic logic [31:0] cfg_word(int p, bit ie, bit au, bit en);
        return (32'(p) << 8) | (32'(ie) << 2) | (32'(au) << 1) | 32'(en);
    endfunction

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7781));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, v); chk("R1 reload", v, 0);
        rd(2'd1, v); chk("R1 count", v, 0);
        rd(2'd2, v); chk("R1 control", v, 0);
        rd(2'd3, v); chk("R1 status", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R2: control field layout, unused bits read zero
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R2 control readback", v, 32'h0000_FF07);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd123);
        rd(2'd0, v); chk("R2 reload readback", v, 123);
        rd(2'd1, v); chk("R2 reload copies to count", v, 123);
        wr(2'd1, 32'd77);
        rd(2'd1, v); chk("R2 count overwrite", v, 77);
        rd(2'd0, v); chk("R2 reload unchanged", v, 123);

        // R3 R4 R5 R6 R9: random configurations
        for (int i = 0; i < 30; i++) begin
            int p  = $urandom_range(0, 7);
            int n  = $urandom_range(1, 20);
            bit au = 1'($urandom_range(0, 1));
            bit ie = 1'($urandom_range(0, 1));
            int k  = $urandom_range(0, (n + 3) * (p + 1) * 2);
            bit st;
            wr(2'd2, cfg_word(p, ie, au, 1'b0));
            wr(2'd0, 32'(n));
            wr(2'd3, 32'd1);
            wr(2'd2, cfg_word(p, ie, au, 1'b1));
            repeat (k) @(negedge clk);
            st = ((k / (p + 1)) >= n);
            rd(2'd1, v);
            chk(au ? "R6 auto count" : "R3 R5 shot count", v, exp_count(n, p, au, k));
            rd(2'd3, v); chk("R4 status", v, 32'(st));
            chk("R9 irq", 32'(irq), 32'(st && ie));
        end

        // R7: freeze holds count and prescale phase
        wr(2'd2, cfg_word(2, 0, 0, 0));
        wr(2'd0, 32'd10);
        wr(2'd2, cfg_word(2, 0, 0, 1));
        repeat (5) @(negedge clk);
        wr(2'd2, cfg_word(2, 0, 0, 0));
        rd(2'd1, v); chk("R7 count at stop", v, 8);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R7 count frozen", v, 8);
        wr(2'd2, cfg_word(2, 0, 0, 1));
        @(negedge clk);
        rd(2'd1, v); chk("R7 resume phase one", v, 8);
        @(negedge clk);
        rd(2'd1, v); chk("R7 resume held phase", v, 7);

        // R10: count write beats a step on the same edge (P=0)
        wr(2'd2, cfg_word(0, 0, 0, 1));
        wr(2'd1, 32'd50);
        rd(2'd1, v); chk("R10 write wins", v, 50);
        @(negedge clk);
        rd(2'd1, v); chk("R3 step after write", v, 49);

        // R8: set beats same-edge clear, zero write ignored, one clears
        wr(2'd2, cfg_word(0, 1, 0, 0));
        wr(2'd0, 32'd1);
        wr(2'd3, 32'd1);
        wr(2'd2, cfg_word(0, 1, 0, 1));
        wr_now(2'd3, 32'd1);
        rd(2'd3, v); chk("R8 set wins over clear", v, 1);
        chk("R9 irq on", 32'(irq), 1);
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R5 stays at zero", v, 0);
        wr(2'd3, 32'd0);
        rd(2'd3, v); chk("R8 zero write ignored", v, 1);
        wr(2'd2, cfg_word(0, 0, 0, 1));
        chk("R9 irq masked", 32'(irq), 0);
        wr(2'd3, 32'd1);
        rd(2'd3, v); chk("R8 one clears", v, 0);
        repeat (5) @(negedge clk);
        rd(2'd3, v); chk("R5 no second event", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule